// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port with Write-Collision Detection

This block moves one byte at a time over a four-wire synchronous serial link, either as the bus master that generates the serial clock or as a slave that follows a clock from another device. Sending and receiving happen together: while the outgoing byte leaves on the data-out pin, the incoming byte enters from the data-in pin. When the byte is done, the received value replaces the contents of the processor-visible buffer.

A processor uses a two-register port: one data register and one control/status register. It programs the mode, the chip-select use, the bit order and the enable bit, then writes a byte to the data register. In master mode that write starts the clock at one of three rates. In slave mode it arms the block, which then waits for the external clock. A completion flag and a level interrupt report the end of each byte. If the processor writes to the data register while a byte is still in flight, a collision flag is set and the byte in progress continues unharmed.

Top module: `spi_port`

## Requirements
- R1: While the enable bit (control bit 4) is 0, a data-register write starts no transfer: the serial clock stays low, busy and done stay 0, and the written byte is simply held in the buffer.
- R2: Mode field (control bits 1:0) values 0, 1 and 2 select master mode with a serial-clock period of 4, 16 and 64 system clocks. The done flag is set on the 8×period-th clock edge after the data write.
- R3: In master mode the serial clock idles low. Data out changes only after falling edges, and data in is sampled on rising edges. With chip-select enable (control bit 2) set, the chip-select output is low from the data write until the byte ends, and high otherwise.
- R4: Control bit 3 = 0 sends and receives the most significant bit first; control bit 3 = 1 sends and receives the least significant bit first. The setting behaves the same in master and slave mode.
- R5: At the end of a byte, the data register reads back the eight bits received on the data-in pin, assembled in the selected bit order.
- R6: A data write while a byte is in flight sets the collision flag (status bit 6). It leaves the outgoing bits, the byte timing and the final buffer contents unchanged.
- R7: Completion sets the done flag (status bit 5), and the interrupt output follows it. A control write with bit 5 = 0 clears done, and one with bit 6 = 0 clears collision; a 1 in either bit leaves that flag as it is.
- R8: Mode value 3 selects slave mode. A data write arms the block (status bit 7 busy = 1), but no bit moves until the external clock toggles. Bits are sampled on its rising edges and the next bit is presented after its falling edges.
- R9: In slave mode with chip-select enable set, a high chip-select input clears the bit count and turns off the data-out driver. With chip-select enable clear, the chip-select input is ignored.
- R10: Address 0 reads the data buffer. Address 1 reads {busy, collision, done, enable, bit-order, chip-select enable, mode[1:0]} from bit 7 down to bit 0. All of these read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 data, 1 control/status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register |
| irq | output | 1 | Byte-complete interrupt (level) |
| sclk_out | output | 1 | Serial clock driven in master mode |
| cs_n_out | output | 1 | Active-low chip select driven in master mode |
| sclk_in | input | 1 | Serial clock from the remote master in slave mode |
| cs_n_in | input | 1 | Active-low chip select from the remote master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
Master transfers run at all three rates and in both bit orders with random outgoing and incoming bytes. The cycle count to done separates the rates, and reversed bytes show whether the bit order was honoured on each direction. Slave transfers run with chip select both used and ignored. A chip-select pulse in mid-byte is used to confirm that the count restarts: eight fresh clocks are then needed, not five. A second write during a slow master byte must raise the collision flag while the captured serial bits and the received byte stay identical to a clean transfer.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    MODE_DIV4  = 2'b00,
    MODE_DIV16 = 2'b01,
    MODE_DIV64 = 2'b10,
    MODE_SLAVE = 2'b11
  } spi_mode_e;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int CTL_CSEN  = 2;
  localparam int CTL_LSB   = 3;
  localparam int CTL_EN    = 4;
  localparam int STS_DONE  = 5;
  localparam int STS_WCOL  = 6;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int H0   = DIV0 / 2;
  localparam int H1   = DIV1 / 2;
  localparam int H2   = DIV2 / 2;
  localparam int HMAX = (H0 > H1) ? ((H0 > H2) ? H0 : H2) : ((H1 > H2) ? H1 : H2);
  localparam int CW   = $clog2(HMAX) + 1;

  logic [CW-1:0] cnt_q, cnt_d, last_cnt;

  always_comb begin
    case (rate)
      2'd0:    last_cnt = CW'(H0 - 1);
      2'd1:    last_cnt = CW'(H1 - 1);
      default: last_cnt = CW'(H2 - 1);
    endcase
  end

  assign tick = run && (cnt_q >= last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // half period is at least two system clocks, so ticks never touch
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lsb_first,
  input  logic          sample,
  input  logic          shift,
  input  logic          sin,
  output logic          sout,
  output logic [DW-1:0] next_data
);
  logic [DW-1:0] data_q, data_d;
  logic          hold_q, hold_d;

  assign next_data = lsb_first ? {hold_q, data_q[DW-1:1]} : {data_q[DW-2:0], hold_q};
  assign sout      = lsb_first ? data_q[0] : data_q[DW-1];

  always_comb begin
    data_d = data_q;
    if (load)       data_d = load_data;
    else if (shift) data_d = next_data;
    hold_d = sample ? sin : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0;
      hold_q <= 1'b0;
    end else begin
      data_q <= data_d;
      hold_q <= hold_d;
    end

  a_r6_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sout == (lsb_first ? $past(load_data[0]) : $past(load_data[DW-1]))));
endmodule

// File: rtl/spi_port.sv
module spi_port import spi_pkg::*; #(
  parameter int DW   = 8,
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          sclk_out,
  output logic          cs_n_out,
  input  logic          sclk_in,
  input  logic          cs_n_in,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  spi_mode_e       mode_q, mode_d;
  logic            csen_q, csen_d, lsb_q, lsb_d, en_q, en_d;
  logic            done_q, done_d, wcol_q, wcol_d, busy_q, busy_d;
  logic            sclk_q, sclk_d, rise_q, rise_d, s_sclk_d;
  logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
  logic [DW-1:0]   buf_q, buf_d, shift_next;
  logic            s_sclk, s_cs_n, s_sdi, tick, sout;

  spi_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_in, cs_n_in, sdi}), .q({s_sclk, s_cs_n, s_sdi}));

  logic is_slave, run, sel_ok, m_rise, m_fall, s_rise, s_fall;
  logic do_sample, do_shift, last, in_flight, wr_data, wr_ctrl, start, collide;

  assign is_slave = (mode_q == MODE_SLAVE);
  assign run      = en_q && busy_q && !is_slave;

  spi_rate_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(mode_q), .tick(tick));

  assign sel_ok    = !csen_q || !s_cs_n;
  assign m_rise    = tick && !sclk_q;
  assign m_fall    = tick && sclk_q;
  assign s_rise    = is_slave && en_q && busy_q && sel_ok && s_sclk && !s_sclk_d;
  assign s_fall    = is_slave && en_q && busy_q && sel_ok && !s_sclk && s_sclk_d && rise_q;
  assign do_sample = m_rise || s_rise;
  assign do_shift  = m_fall || s_fall;
  assign last      = (bitcnt_q == LAST_BIT);
  assign in_flight = is_slave ? (busy_q && (bitcnt_q != '0 || rise_q)) : busy_q;
  assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
  assign start     = wr_data && en_q && !in_flight;
  assign collide   = wr_data && en_q && in_flight;

  spi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(reg_wdata),
    .lsb_first(lsb_q), .sample(do_sample), .shift(do_shift),
    .sin(is_slave ? s_sdi : sdi), .sout(sout), .next_data(shift_next));

  always_comb begin
    mode_d = mode_q; csen_d = csen_q; lsb_d = lsb_q; en_d = en_q;
    done_d = done_q; wcol_d = wcol_q; busy_d = busy_q; sclk_d = sclk_q;
    rise_d = rise_q; bitcnt_d = bitcnt_q; buf_d = buf_q;
    if (wr_ctrl) begin
      mode_d = spi_mode_e'(reg_wdata[1:0]);
      csen_d = reg_wdata[CTL_CSEN];
      lsb_d  = reg_wdata[CTL_LSB];
      en_d   = reg_wdata[CTL_EN];
      done_d = done_q && reg_wdata[STS_DONE];
      wcol_d = wcol_q && reg_wdata[STS_WCOL];
    end
    if (!en_q) begin
      busy_d = 1'b0; sclk_d = 1'b0; rise_d = 1'b0; bitcnt_d = '0;
      if (wr_data) buf_d = reg_wdata;
    end else begin
      if (start) begin
        busy_d = 1'b1; sclk_d = 1'b0; rise_d = 1'b0; bitcnt_d = '0;
        buf_d  = reg_wdata;
      end
      if (collide) wcol_d = 1'b1;
      if (do_sample) begin
        rise_d = 1'b1;
        if (m_rise) sclk_d = 1'b1;
      end
      if (do_shift) begin
        rise_d   = 1'b0;
        sclk_d   = 1'b0;
        bitcnt_d = bitcnt_q + 1'b1;
        if (last) begin
          busy_d = 1'b0; done_d = 1'b1; bitcnt_d = '0;
          buf_d  = shift_next;
        end
      end
      if (is_slave && csen_q && s_cs_n) begin
        bitcnt_d = '0; rise_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= MODE_DIV4; csen_q <= 1'b0; lsb_q <= 1'b0; en_q <= 1'b0;
      done_q <= 1'b0; wcol_q <= 1'b0; busy_q <= 1'b0; sclk_q <= 1'b0;
      rise_q <= 1'b0; bitcnt_q <= '0; buf_q <= '0; s_sclk_d <= 1'b0;
    end else begin
      mode_q <= mode_d; csen_q <= csen_d; lsb_q <= lsb_d; en_q <= en_d;
      done_q <= done_d; wcol_q <= wcol_d; busy_q <= busy_d; sclk_q <= sclk_d;
      rise_q <= rise_d; bitcnt_q <= bitcnt_d; buf_q <= buf_d; s_sclk_d <= s_sclk;
    end

  logic [7:0] status;
  assign status    = {busy_q, wcol_q, done_q, en_q, lsb_q, csen_q, mode_q};
  assign reg_rdata = (reg_addr == ADDR_CTRL) ? DW'(status) : buf_q;
  assign irq       = done_q;
  assign sclk_out  = sclk_q;
  assign cs_n_out  = !(en_q && busy_q && csen_q && !is_slave);
  assign sdo       = sout;
  assign sdo_oe    = en_q && (!is_slave || sel_ok);

  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !busy_q);
  a_r3_clock_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_out);
  a_r6_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && en_q && busy_q && !is_slave) |=> wcol_q);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(bitcnt_q) == LAST_BIT));
  a_r9_cs_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && csen_q && s_cs_n) |=> (bitcnt_q == '0));
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  localparam int CLK_NS = 5;
  localparam int SH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, sclk_out, cs_n_out, sdo, sdo_oe;
  logic sclk_in = 1'b0, cs_n_in = 1'b1, slave_sdi = 1'b0;
  logic use_model = 1'b1;
  logic sdi;

  int checks = 0, failures = 0;

  // remote slave model for master-mode transfers
  logic [7:0] m_byte = '0;
  logic       m_lsb  = 1'b0;
  int         edges  = 0, base = 0;
  logic [7:0] cap_q  = '0;
  logic       cs_bad = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sclk_out(sclk_out), .cs_n_out(cs_n_out), .sclk_in(sclk_in),
    .cs_n_in(cs_n_in), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  function automatic logic bit_at(logic [7:0] b, logic lsb, int i);
    if (i < 0 || i > 7) return 1'b0;
    return lsb ? b[i] : b[7-i];
  endfunction

  function automatic logic [7:0] arrival(logic [7:0] b, logic lsb);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = bit_at(b, lsb, i);
    return r;
  endfunction

  function automatic logic [7:0] ctl(int mode, logic csen, logic lsb, logic en,
                                     logic keep_done, logic keep_wcol);
    return {1'b0, keep_wcol, keep_done, en, lsb, csen, 2'(mode)};
  endfunction

  assign sdi = use_model ? bit_at(m_byte, m_lsb, edges - base) : slave_sdi;

  always @(posedge sclk_out) begin
    cap_q  <= {cap_q[6:0], sdo};
    if (cs_n_out) cs_bad <= 1'b1;
    edges  <= edges + 1;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(input int limit, output int cycles);
    logic [7:0] s;
    cycles = 0;
    rd(1'b1, s);
    while (!s[5] && cycles < limit) begin
      @(posedge clk); @(negedge clk);
      cycles++;
      rd(1'b1, s);
    end
  endtask

  task automatic master_xfer(input int mode, input logic lsb, input logic csen,
                             input logic [7:0] tx, input logic [7:0] rx,
                             input logic collide_mid);
    int cyc, per;
    logic [7:0] s, d;
    per = 4 << (2 * mode);
    wr(1'b1, ctl(mode, csen, lsb, 1'b1, 1'b0, 1'b0));
    use_model = 1'b1; m_byte = rx; m_lsb = lsb; base = edges; cs_bad = 1'b0;
    wr(1'b0, tx);
    if (collide_mid) begin
      repeat (per * 3) @(negedge clk);
      wr(1'b0, ~tx);
      rd(1'b1, s);
      chk(s[6] == 1'b1, "R6", "collision flag", s[6], 1);
      wait_done(20000, cyc);
      cyc = cyc + per * 3 + 1;
    end else begin
      wait_done(20000, cyc);
    end
    chk(cyc == 8 * per, "R2", "cycles to done", cyc, 8 * per);
    chk(cap_q == arrival(tx, lsb), "R3/R4", "serial bits out", cap_q, arrival(tx, lsb));
    rd(1'b0, d);
    chk(d == rx, "R5", "received byte", d, rx);
    chk(irq == 1'b1, "R7", "irq after byte", irq, 1);
    if (csen) chk(!cs_bad && cs_n_out, "R3", "chip select framing", cs_bad, 0);
    chk(sclk_out == 1'b0, "R3", "clock idle low", sclk_out, 0);
  endtask

  task automatic slave_bits(input logic [7:0] rx, input logic lsb, input int first,
                            input int n, inout logic [7:0] cap);
    for (int i = first; i < first + n; i++) begin
      slave_sdi = bit_at(rx, lsb, i);
      repeat (SH) @(negedge clk);
      cap = {cap[6:0], sdo};
      sclk_in = 1'b1;
      repeat (SH) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (SH) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic lsb, input logic csen,
                            input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] s, d, cap;
    cap = '0;
    use_model = 1'b0; cs_n_in = 1'b1;
    wr(1'b1, ctl(3, csen, lsb, 1'b1, 1'b0, 1'b0));
    wr(1'b0, tx);
    repeat (50) @(negedge clk);
    rd(1'b1, s);
    chk(s[7] == 1'b1 && s[5] == 1'b0, "R8", "armed, waiting for clock", s, 8'h80);
    chk(sdo_oe == !csen, "R9", "data-out driver with cs high", sdo_oe, !csen);
    if (csen) cs_n_in = 1'b0;
    repeat (SH) @(negedge clk);
    slave_bits(rx, lsb, 0, 8, cap);
    cs_n_in = 1'b1;
    rd(1'b1, s);
    chk(s[5] == 1'b1, "R8", "slave done", s[5], 1);
    chk(cap == arrival(tx, lsb), "R4/R8", "slave serial bits out", cap, arrival(tx, lsb));
    rd(1'b0, d);
    chk(d == rx, "R5", "slave received byte", d, rx);
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] s, d, cap;
    int cyc;
    bit seen_clk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(1'b1, s);
    chk(s == 8'h00, "R10", "status after reset", s, 0);
    rd(1'b0, d);
    chk(d == 8'h00, "R10", "buffer after reset", d, 0);
    chk(irq == 0 && sclk_out == 0 && cs_n_out == 1, "R10", "pins after reset",
        {irq, sclk_out, cs_n_out}, 3'b001);

    // R1 disabled: write stored, nothing moves
    wr(1'b1, ctl(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(1'b0, 8'hA5);
    seen_clk = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sclk_out) seen_clk = 1;
    end
    chk(!seen_clk, "R1", "no clock while disabled", seen_clk, 0);
    rd(1'b1, s);
    chk(s[7] == 0 && s[5] == 0, "R1", "busy/done while disabled", s, 8'h07 & s);
    rd(1'b0, d);
    chk(d == 8'hA5, "R1", "buffer holds written byte", d, 8'hA5);

    // R2..R5, R7 directed: all rates, both orders
    for (int m = 0; m < 3; m++)
      for (int l = 0; l < 2; l++)
        master_xfer(m, l[0], 1'b1, 8'(8'h96 ^ (m * 37 + l)), 8'(8'h3C + m * 11 + l), 1'b0);

    // R7 clear semantics: write 1 keeps, write 0 clears
    wr(1'b1, ctl(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    rd(1'b1, s);
    chk(s[5] == 1'b1, "R7", "done kept on write of 1", s[5], 1);
    wr(1'b1, ctl(0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    rd(1'b1, s);
    chk(s[5] == 1'b0 && irq == 1'b0, "R7", "done cleared", s[5], 0);
    chk(s[6] == 1'b0, "R6", "no collision on idle write", s[6], 0);

    // R6 collision during slow transfer
    master_xfer(2, 1'b0, 1'b1, 8'hC3, 8'h5A, 1'b1);
    wr(1'b1, ctl(2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    rd(1'b1, s);
    chk(s[6] == 1'b0 && s[5] == 1'b1, "R7", "collision cleared, done kept", s[6:5], 2'b01);

    // random master transfers
    for (int k = 0; k < 6; k++)
      master_xfer(int'($urandom_range(2)), 1'($urandom), 1'($urandom),
                  8'($urandom), 8'($urandom), 1'b0);

    // R8/R9 slave transfers, cs used and ignored
    slave_xfer(1'b0, 1'b1, 8'h81, 8'h7E);
    slave_xfer(1'b1, 1'b0, 8'h2D, 8'hB4);
    for (int k = 0; k < 4; k++)
      slave_xfer(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));

    // R9 chip select pulse mid-byte restarts the count
    cap = '0;
    wr(1'b1, ctl(3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    wr(1'b0, 8'h55);
    cs_n_in = 1'b0;
    repeat (SH) @(negedge clk);
    slave_bits(8'hFF, 1'b0, 0, 3, cap);
    cs_n_in = 1'b1;
    repeat (SH) @(negedge clk);
    chk(sdo_oe == 1'b0, "R9", "driver off while deselected", sdo_oe, 0);
    cs_n_in = 1'b0;
    repeat (SH) @(negedge clk);
    slave_bits(8'hFF, 1'b0, 0, 7, cap);
    rd(1'b1, s);
    chk(s[5] == 1'b0, "R9", "not done after 7 fresh clocks", s[5], 0);
    slave_bits(8'hFF, 1'b0, 7, 1, cap);
    rd(1'b1, s);
    chk(s[5] == 1'b1, "R9", "done after 8th fresh clock", s[5], 1);
    cs_n_in = 1'b1;

    // R10 control readback
    wr(1'b1, ctl(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    rd(1'b1, s);
    chk(s == 8'h19, "R10", "control readback", s, 8'h19);
    wait_done(1, cyc);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule